// File: doc/BRIEF.md
# Host-to-Audio Command Mailbox

This block carries single-byte commands from a host processor to an audio-controller processor. The host issues one store to a dedicated strobe input. The byte is latched, a fast interrupt is raised toward the audio side, and the same byte is appended to a circular command queue. The audio side reads the latched byte from its command register at address 0x2002. That read retires the interrupt. Queued bytes are drained later through a separate pop port.

The audio side also owns an 8-bit status register at address 0x2000. Bit 0 of this register is presented to the host as a ready flag. Bit 7 drives the reset line of the downstream signal processor. The queue uses a begin index and an end index, each 8 bits wide. One slot of the 16-entry store is always left unused, so that a full queue can be told apart from an empty one. A push that arrives while the queue is full is discarded and sets a sticky overflow flag.

Top module: `snd_cmd_mailbox`

## Requirements
- R1: After a synchronous reset, cmd_irq, dsp_reset, host_ready, q_overflow, q_full and aud_rdata are all 0, and q_empty is 1.
- R2: A cycle with host_strobe high latches host_cmd and sets cmd_irq. Both are visible from the next cycle.
- R3: A read with aud_addr = 0x2002 puts the latched byte on aud_rdata in the following cycle and clears cmd_irq. If a strobe arrives in the same cycle, the read returns the older byte and cmd_irq stays 1.
- R4: A second read of 0x2002 with no strobe in between returns the same byte, and cmd_irq stays 0.
- R5: Every strobe appends its byte to the queue. A q_pop on a non-empty queue puts the oldest byte on q_data in the next cycle. q_empty is 1 exactly when the begin index equals the end index. A pop on an empty queue changes nothing.
- R6: q_full is 1 when (end+1) mod 16 equals begin, so the queue holds at most 15 bytes. A strobe while the queue is full leaves the queue contents unchanged.
- R7: A strobe while the queue is full sets q_overflow. The flag stays 1 until reset, even after the queue is drained.
- R8: A write with aud_addr = 0x2000 stores aud_wdata into the status register. Bit 7 drives dsp_reset and bit 0 drives host_ready. A read of 0x2000 returns the whole stored byte.
- R9: A read of any address other than 0x2000 or 0x2002 returns 0x00. A write to any address other than 0x2000, including 0x2002, changes neither the status register nor the latched command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | Host store to the command strobe |
| host_cmd | input | 8 | Command byte from the host |
| aud_rd | input | 1 | Audio-side read enable |
| aud_wr | input | 1 | Audio-side write enable |
| aud_addr | input | 16 | Audio-side address |
| aud_wdata | input | 8 | Audio-side write data |
| aud_rdata | output | 8 | Registered audio-side read data |
| cmd_irq | output | 1 | Fast interrupt toward the audio side |
| dsp_reset | output | 1 | Reset for the downstream signal processor |
| host_ready | output | 1 | Ready flag toward the host |
| q_pop | input | 1 | Remove the oldest queued byte |
| q_data | output | 8 | Byte removed by the last pop |
| q_empty | output | 1 | Queue holds no bytes |
| q_full | output | 1 | Queue holds 15 bytes |
| q_overflow | output | 1 | Sticky flag: a byte was dropped |

## Verification
The bench builds the block with its default parameters: a 16-slot store, 8-bit indices and the two register addresses. With these values, fifteen strobes fill the queue and a sixteenth overflows it, which exercises the full boundary and the dropped byte. Because the queue first advances by three entries and then goes through a full fill and drain, both indices wrap past slot 15 back to slot 0. A table of status-register values checks the reset bit and the ready bit on their own and together. Directed cases cover a strobe and a read in the same cycle, and a repeated read of the command register.

// File: rtl/snd_mbox_pkg.sv
package snd_mbox_pkg;
  localparam int ADDR_W       = 16;
  localparam int DATA_W       = 8;
  localparam int STAT_RST_BIT = 7;
  localparam int STAT_RDY_BIT = 0;
  localparam logic [ADDR_W-1:0] STAT_ADDR_DEF = 16'h2000;
  localparam logic [ADDR_W-1:0] CMD_ADDR_DEF  = 16'h2002;
endpackage

// File: rtl/snd_cmd_latch.sv
module snd_cmd_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] strobe_data,
  input  logic          take,
  output logic [DW-1:0] cmd_q,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (strobe) cmd_q <= strobe_data;
      if (strobe)    irq <= 1'b1;
      else if (take) irq <= 1'b0;
    end
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    strobe |=> irq && cmd_q == $past(strobe_data)); // R2
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    take && !strobe |=> !irq); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !strobe && !irq |=> !irq && $stable(cmd_q)); // R4
endmodule

// File: rtl/snd_cmd_ring.sv
module snd_cmd_ring #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int PTR_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          full,
  output logic          ovf
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] beg_q, end_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (beg_q == end_q);
  assign full  = (nxt(end_q) == beg_q);

  always_ff @(posedge clk) begin
    if (push && !full) mem[end_q[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                pop_data <= '0;
    else if (pop && !empty) pop_data <= mem[beg_q[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beg_q <= '0;
      end_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push && !full) end_q <= nxt(end_q);
      if (pop && !empty) beg_q <= nxt(beg_q);
      if (push && full)  ovf   <= 1'b1;
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    end_q < PTR_W'(DEPTH) && beg_q < PTR_W'(DEPTH)); // R5
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop && empty |=> $stable(beg_q)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    push && full |=> $stable(end_q) && ovf); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R7
endmodule

// File: rtl/snd_status_reg.sv
module snd_status_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (rst)     stat_q <= '0;
    else if (we) stat_q <= wdata;
  end

  AST_STAT_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> stat_q == $past(wdata)); // R8
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(stat_q)); // R9
endmodule

// File: rtl/snd_cmd_mailbox.sv
module snd_cmd_mailbox
  import snd_mbox_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int DEPTH = 16,
  parameter int PTR_W = 8,
  parameter logic [AW-1:0] STAT_ADDR = STAT_ADDR_DEF,
  parameter logic [AW-1:0] CMD_ADDR  = CMD_ADDR_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_strobe,
  input  logic [DW-1:0] host_cmd,
  input  logic          aud_rd,
  input  logic          aud_wr,
  input  logic [AW-1:0] aud_addr,
  input  logic [DW-1:0] aud_wdata,
  output logic [DW-1:0] aud_rdata,
  output logic          cmd_irq,
  output logic          dsp_reset,
  output logic          host_ready,
  input  logic          q_pop,
  output logic [DW-1:0] q_data,
  output logic          q_empty,
  output logic          q_full,
  output logic          q_overflow
);
  logic          hit_stat, hit_cmd;
  logic [DW-1:0] cmd_q, stat_q;

  assign hit_stat = (aud_addr == STAT_ADDR);
  assign hit_cmd  = (aud_addr == CMD_ADDR);

  snd_cmd_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst(rst), .strobe(host_strobe), .strobe_data(host_cmd),
    .take(aud_rd && hit_cmd), .cmd_q(cmd_q), .irq(cmd_irq)
  );

  snd_cmd_ring #(.DW(DW), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ring (
    .clk(clk), .rst(rst), .push(host_strobe), .push_data(host_cmd),
    .pop(q_pop), .pop_data(q_data), .empty(q_empty), .full(q_full),
    .ovf(q_overflow)
  );

  snd_status_reg #(.DW(DW)) u_stat (
    .clk(clk), .rst(rst), .we(aud_wr && hit_stat), .wdata(aud_wdata),
    .stat_q(stat_q)
  );

  assign dsp_reset  = stat_q[STAT_RST_BIT];
  assign host_ready = stat_q[STAT_RDY_BIT];

  always_ff @(posedge clk) begin
    if (rst) aud_rdata <= '0;
    else if (aud_rd) begin
      if (hit_stat)     aud_rdata <= stat_q;
      else if (hit_cmd) aud_rdata <= cmd_q;
      else              aud_rdata <= '0;
    end
  end

  AST_EMPTY_FULL: assert property (@(posedge clk) disable iff (rst)
    !(q_empty && q_full)); // R6
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    aud_rd && !hit_stat && !hit_cmd |=> aud_rdata == '0); // R9
endmodule

// File: tb/tb_snd_cmd_mailbox.sv
module tb_snd_cmd_mailbox;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_strobe, aud_rd, aud_wr, q_pop;
  logic [7:0]  host_cmd, aud_wdata, aud_rdata, q_data;
  logic [15:0] aud_addr;
  logic        cmd_irq, dsp_reset, host_ready, q_empty, q_full, q_overflow;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  snd_cmd_mailbox dut (
    .clk(clk), .rst(rst), .host_strobe(host_strobe), .host_cmd(host_cmd),
    .aud_rd(aud_rd), .aud_wr(aud_wr), .aud_addr(aud_addr),
    .aud_wdata(aud_wdata), .aud_rdata(aud_rdata), .cmd_irq(cmd_irq),
    .dsp_reset(dsp_reset), .host_ready(host_ready), .q_pop(q_pop),
    .q_data(q_data), .q_empty(q_empty), .q_full(q_full),
    .q_overflow(q_overflow)
  );

  // {write value, expected dsp_reset, expected host_ready}
  localparam logic [9:0] STAT_VEC [5] = '{
    {8'h80, 1'b1, 1'b0}, {8'h01, 1'b0, 1'b1}, {8'h81, 1'b1, 1'b1},
    {8'h7E, 1'b0, 1'b0}, {8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] b);
    host_strobe = 1'b1; host_cmd = b;
    @(negedge clk);
    host_strobe = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    aud_rd = 1'b1; aud_addr = a;
    @(negedge clk);
    aud_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    aud_wr = 1'b1; aud_addr = a; aud_wdata = d;
    @(negedge clk);
    aud_wr = 1'b0;
  endtask

  task automatic pop();
    q_pop = 1'b1;
    @(negedge clk);
    q_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; host_strobe = 0; aud_rd = 0; aud_wr = 0; q_pop = 0;
    host_cmd = 0; aud_wdata = 0; aud_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", cmd_irq, 0);   chk("R1 dsp_reset", dsp_reset, 0);
    chk("R1 ready", host_ready, 0); chk("R1 ovf", q_overflow, 0);
    chk("R1 empty", q_empty, 1); chk("R1 full", q_full, 0);
    chk("R1 rdata", aud_rdata, 0);

    // R8 status table
    foreach (STAT_VEC[i]) begin
      wr(16'h2000, STAT_VEC[i][9:2]);
      chk("R8 dsp_reset", dsp_reset, STAT_VEC[i][1]);
      chk("R8 ready", host_ready, STAT_VEC[i][0]);
      rd(16'h2000);
      chk("R8 readback", aud_rdata, STAT_VEC[i][9:2]);
    end

    // R9 unmapped read and write elsewhere
    wr(16'h2000, 8'h81);
    wr(16'h2004, 8'h00);
    chk("R9 stat kept", {dsp_reset, host_ready}, 2'b11);
    rd(16'h2004);
    chk("R9 unmapped read", aud_rdata, 0);

    // R2 R3 R4 command path
    strobe(8'h5A);
    chk("R2 irq set", cmd_irq, 1);
    wr(16'h2002, 8'hC3);
    chk("R9 cmd write ignored irq", cmd_irq, 1);
    rd(16'h2002);
    chk("R3 read byte", aud_rdata, 8'h5A);
    chk("R3 irq cleared", cmd_irq, 0);
    rd(16'h2000);
    rd(16'h2002);
    chk("R4 same byte", aud_rdata, 8'h5A);
    chk("R4 no irq", cmd_irq, 0);

    // R3 strobe and read in the same cycle
    strobe(8'h11);
    host_strobe = 1'b1; host_cmd = 8'h22; aud_rd = 1'b1; aud_addr = 16'h2002;
    @(negedge clk);
    host_strobe = 1'b0; aud_rd = 1'b0;
    chk("R3 collide old byte", aud_rdata, 8'h11);
    chk("R3 collide irq kept", cmd_irq, 1);
    rd(16'h2002);
    chk("R3 newer byte", aud_rdata, 8'h22);

    // R5 queue order
    chk("R5 not empty", q_empty, 0);
    pop(); chk("R5 pop1", q_data, 8'h5A);
    pop(); chk("R5 pop2", q_data, 8'h11);
    pop(); chk("R5 pop3", q_data, 8'h22);
    chk("R5 empty", q_empty, 1);
    pop(); chk("R5 pop empty no change", q_data, 8'h22);

    // R6 R7 fill, overflow, drain (indices wrap)
    for (int k = 0; k < 15; k++) strobe(8'hA0 + 8'(k));
    chk("R6 full at 15", q_full, 1);
    chk("R7 no ovf yet", q_overflow, 0);
    strobe(8'hEE);
    chk("R7 ovf set", q_overflow, 1);
    chk("R6 still full", q_full, 1);
    for (int k = 0; k < 15; k++) begin
      pop();
      chk("R6 drain order", q_data, 8'hA0 + 8'(k));
    end
    chk("R6 empty after drain, drop lost", q_empty, 1);
    chk("R7 ovf sticky", q_overflow, 1);

    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 ovf cleared by reset", q_overflow, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule